// File: doc/BRIEF.md
# Scan Chain Pattern Fault Classifier

This block runs the first step of scan chain diagnosis. For each chain in turn it shifts a repeating two-zeros, two-ones pattern into the chain's scan input for twice the chain length, throws away the first chain-length bits that come back, and records what the unload looks like at each of the four positions of the pattern period. From that record it names the chain as good, stuck at 0, stuck at 1, or one of four transition timing faults: slow rise, slow fall, fast rise or fast fall. Any other unload is reported as an unclassified fault.

Chains are visited in ascending index order through a chain-select output that steers an external multiplexer. That multiplexer routes the scan input and shift enable to the selected chain and returns its scan output. The sweep stops at the first chain that is not good and reports that chain's index and fault code. If every chain is good the sweep ends with the good code and index 0. Finding the faulty cell inside the chain is left to later steps.

Top module: `chain_pattern_classifier`

## Requirements
- R1: After reset, scan_en_o, done_o and scan_in_o are 0, fault_code_o is 0 (good) and fail_chain_o is 0.
- R2: Each chain gets one shift window of exactly 2*CHAIN_LEN cycles with scan_en_o high. In that window scan_in_o repeats 0,0,1,1, starting with 0 in the window's first cycle.
- R3: A chain whose unload repeats 0,0,1,1 (first-out bit first) is reported as good, code 000.
- R4: An unload of all zeros gives code 001 (stuck at 0). An unload of all ones gives code 010 (stuck at 1).
- R5: Timing faults are named by the unload bits at period positions 0..3, written first-out first. 0,0,1,0 gives slow rise (011). 0,1,1,1 gives slow fall (100). 1,0,1,1 gives fast rise (101). 0,0,0,1 gives fast fall (110).
- R6: Any other unload gives code 111 (unclassified). This includes an unload where one period position does not hold the same value in every period.
- R7: The first CHAIN_LEN scan-out bits of each window come from the chain's earlier contents and do not affect the result.
- R8: Chains are tested in ascending index order and the sweep stops at the first failing chain. fail_chain_o is that chain's index. When all chains are good, fail_chain_o is 0.
- R9: done_o rises exactly (2*CHAIN_LEN+1)*k cycles after the clock edge that accepts start_i, where k is the number of chains tested. scan_en_o and done_o are never high together.
- R10: start_i is ignored while a sweep is running. When start_i is high while idle or done, a new sweep begins and done_o is low from the next cycle.
- R11: While done_o is high and start_i is low, done_o, fault_code_o and fail_chain_o hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a sweep over all chains |
| scan_out_i | input | 1 | Scan output of the selected chain |
| scan_in_o | output | 1 | Pattern bit for the selected chain's scan input |
| scan_en_o | output | 1 | Shift enable for the selected chain |
| chain_sel_o | output | SEL_W | Index of the chain under test |
| done_o | output | 1 | Sweep finished, results valid |
| fault_code_o | output | 3 | Fault class of the reported chain |
| fail_chain_o | output | SEL_W | Index of the first failing chain (0 if none) |

## Verification
The assertions assume that start_i may arrive in any cycle and that scan_out_i carries meaning only in the unload half of a window. They also assume CHAIN_LEN is at least 4, so that every period position is seen at least once. The stimulus fills each chain with random contents before every sweep, so the discarded half of each window holds noise. Faults are injected only as per-position values or single flipped bits in the unload half, so every expected code follows from the tables in R3 to R6. Start pulses are also placed inside a running sweep to check that they are ignored.

// File: rtl/cptc_pkg.sv
package cptc_pkg;

  localparam int PAT_PERIOD = 4;

  typedef enum logic [2:0] {
    FC_GOOD      = 3'd0,
    FC_SA0       = 3'd1,
    FC_SA1       = 3'd2,
    FC_SLOW_RISE = 3'd3,
    FC_SLOW_FALL = 3'd4,
    FC_FAST_RISE = 3'd5,
    FC_FAST_FALL = 3'd6,
    FC_UNKNOWN   = 3'd7
  } fault_code_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_SHIFT,
    SQ_EVAL,
    SQ_DONE
  } seq_state_e;

endpackage

// File: rtl/cptc_pattern_gen.sv
module cptc_pattern_gen (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart_i,
  input  logic       advance_i,
  output logic       pat_bit_o,
  output logic [1:0] phase_o
);

  logic [1:0] phase_q, phase_d;
  logic       phase_en;

  assign phase_en = restart_i | advance_i;

  always_comb begin
    if (restart_i) phase_d = 2'd0;
    else           phase_d = phase_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        phase_q <= 2'd0;
    else if (phase_en) phase_q <= phase_d;
  end

  // positions 0,1 carry 0 and positions 2,3 carry 1
  assign pat_bit_o = phase_q[1];
  assign phase_o   = phase_q;

endmodule

// File: rtl/cptc_sig_accum.sv
module cptc_sig_accum import cptc_pkg::*; (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr_i,
  input  logic                  smp_en_i,
  input  logic [1:0]            pos_i,
  input  logic                  bit_i,
  output logic [PAT_PERIOD-1:0] seen0_o,
  output logic [PAT_PERIOD-1:0] seen1_o
);

  logic [PAT_PERIOD-1:0] seen0_q, seen1_q;

  for (genvar p = 0; p < PAT_PERIOD; p++) begin : g_pos
    logic hit, en, s0_d, s1_d;
    assign hit  = smp_en_i && (pos_i == 2'(p));
    assign en   = clr_i | hit;
    assign s0_d = clr_i ? 1'b0 : (seen0_q[p] | ~bit_i);
    assign s1_d = clr_i ? 1'b0 : (seen1_q[p] |  bit_i);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        seen0_q[p] <= 1'b0;
        seen1_q[p] <= 1'b0;
      end else if (en) begin
        seen0_q[p] <= s0_d;
        seen1_q[p] <= s1_d;
      end
    end
  end

  assign seen0_o = seen0_q;
  assign seen1_o = seen1_q;

endmodule

// File: rtl/cptc_classifier.sv
module cptc_classifier import cptc_pkg::*; (
  input  logic [PAT_PERIOD-1:0] seen0_i,
  input  logic [PAT_PERIOD-1:0] seen1_i,
  output fault_code_e           code_o
);

  // bit p of each constant is the unload value at period position p
  localparam logic [3:0] SIG_GOOD = 4'b1100;
  localparam logic [3:0] SIG_SA0  = 4'b0000;
  localparam logic [3:0] SIG_SA1  = 4'b1111;
  localparam logic [3:0] SIG_SR   = 4'b0100;
  localparam logic [3:0] SIG_SF   = 4'b1110;
  localparam logic [3:0] SIG_FR   = 4'b1101;
  localparam logic [3:0] SIG_FF   = 4'b1000;

  logic all_seen, mixed;

  assign all_seen = &(seen0_i | seen1_i);
  assign mixed    = |(seen0_i & seen1_i);

  always_comb begin
    code_o = FC_UNKNOWN;
    if (all_seen && !mixed) begin
      case (seen1_i)
        SIG_GOOD: code_o = FC_GOOD;
        SIG_SA0:  code_o = FC_SA0;
        SIG_SA1:  code_o = FC_SA1;
        SIG_SR:   code_o = FC_SLOW_RISE;
        SIG_SF:   code_o = FC_SLOW_FALL;
        SIG_FR:   code_o = FC_FAST_RISE;
        SIG_FF:   code_o = FC_FAST_FALL;
        default:  code_o = FC_UNKNOWN;
      endcase
    end
  end

endmodule

// File: rtl/cptc_sequencer.sv
module cptc_sequencer import cptc_pkg::*; #(
  parameter int NUM_CHAINS = 4,
  parameter int CHAIN_LEN  = 12,
  localparam int SEL_W     = (NUM_CHAINS > 1) ? $clog2(NUM_CHAINS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  fault_code_e      chain_code_i,
  output logic             shift_en_o,
  output logic             clr_o,
  output logic             smp_en_o,
  output logic [SEL_W-1:0] chain_sel_o,
  output logic             done_o,
  output fault_code_e      code_o,
  output logic [SEL_W-1:0] fail_idx_o
);

  localparam int               SHIFT_CYC   = 2 * CHAIN_LEN;
  localparam int               CNT_W       = $clog2(SHIFT_CYC);
  localparam logic [CNT_W-1:0] LAST_CNT    = CNT_W'(SHIFT_CYC - 1);
  localparam logic [CNT_W-1:0] UNLOAD_FROM = CNT_W'(CHAIN_LEN);
  localparam logic [SEL_W-1:0] LAST_CHAIN  = SEL_W'(NUM_CHAINS - 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  fault_code_e      code_q, code_d;
  logic [SEL_W-1:0] idx_q, idx_d;
  logic             res_en, clr;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sel_d   = sel_q;
    code_d  = code_q;
    idx_d   = idx_q;
    res_en  = 1'b0;
    clr     = 1'b0;
    case (state_q)
      SQ_IDLE, SQ_DONE: begin
        if (start_i) begin
          state_d = SQ_SHIFT;
          cnt_d   = '0;
          sel_d   = '0;
          code_d  = FC_GOOD;
          idx_d   = '0;
          res_en  = 1'b1;
          clr     = 1'b1;
        end
      end
      SQ_SHIFT: begin
        if (cnt_q == LAST_CNT) state_d = SQ_EVAL;
        else                   cnt_d   = cnt_q + 1'b1;
      end
      SQ_EVAL: begin
        if (chain_code_i != FC_GOOD) begin
          state_d = SQ_DONE;
          code_d  = chain_code_i;
          idx_d   = sel_q;
          res_en  = 1'b1;
        end else if (sel_q == LAST_CHAIN) begin
          state_d = SQ_DONE;
        end else begin
          state_d = SQ_SHIFT;
          cnt_d   = '0;
          sel_d   = sel_q + 1'b1;
          clr     = 1'b1;
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
      sel_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sel_q   <= sel_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= FC_GOOD;
      idx_q  <= '0;
    end else if (res_en) begin
      code_q <= code_d;
      idx_q  <= idx_d;
    end
  end

  assign shift_en_o  = (state_q == SQ_SHIFT);
  assign smp_en_o    = (state_q == SQ_SHIFT) && (cnt_q >= UNLOAD_FROM);
  assign clr_o       = clr;
  assign chain_sel_o = sel_q;
  assign done_o      = (state_q == SQ_DONE);
  assign code_o      = code_q;
  assign fail_idx_o  = idx_q;

endmodule

// File: rtl/chain_pattern_classifier.sv
module chain_pattern_classifier import cptc_pkg::*; #(
  parameter int NUM_CHAINS = 4,
  parameter int CHAIN_LEN  = 12,
  localparam int SEL_W     = (NUM_CHAINS > 1) ? $clog2(NUM_CHAINS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             scan_out_i,
  output logic             scan_in_o,
  output logic             scan_en_o,
  output logic [SEL_W-1:0] chain_sel_o,
  output logic             done_o,
  output logic [2:0]       fault_code_o,
  output logic [SEL_W-1:0] fail_chain_o
);

  // position offset between the pattern driven now and the bit returning now
  localparam logic [1:0] POS_SKEW = 2'(CHAIN_LEN % PAT_PERIOD);

  logic                  shift_en, clr, smp_en;
  logic [1:0]            drv_pos, obs_pos;
  logic [PAT_PERIOD-1:0] seen0, seen1;
  fault_code_e           chain_code, res_code;

  cptc_sequencer #(
    .NUM_CHAINS (NUM_CHAINS),
    .CHAIN_LEN  (CHAIN_LEN)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .chain_code_i (chain_code),
    .shift_en_o   (shift_en),
    .clr_o        (clr),
    .smp_en_o     (smp_en),
    .chain_sel_o  (chain_sel_o),
    .done_o       (done_o),
    .code_o       (res_code),
    .fail_idx_o   (fail_chain_o)
  );

  cptc_pattern_gen u_pat (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (clr),
    .advance_i (shift_en),
    .pat_bit_o (scan_in_o),
    .phase_o   (drv_pos)
  );

  assign obs_pos = drv_pos - POS_SKEW;

  cptc_sig_accum u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (clr),
    .smp_en_i (smp_en),
    .pos_i    (obs_pos),
    .bit_i    (scan_out_i),
    .seen0_o  (seen0),
    .seen1_o  (seen1)
  );

  cptc_classifier u_cls (
    .seen0_i (seen0),
    .seen1_i (seen1),
    .code_o  (chain_code)
  );

  assign scan_en_o    = shift_en;
  assign fault_code_o = res_code;

endmodule

// File: rtl/cptc_checker.sv
module cptc_checker #(
  parameter int NUM_CHAINS = 4,
  parameter int CHAIN_LEN  = 12,
  localparam int SEL_W     = (NUM_CHAINS > 1) ? $clog2(NUM_CHAINS) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             scan_in_o,
  input logic             scan_en_o,
  input logic             done_o,
  input logic [2:0]       fault_code_o,
  input logic [SEL_W-1:0] fail_chain_o
);

  localparam int WIN = 2 * CHAIN_LEN;
  localparam int EW  = $clog2(WIN + 1) + 1;

  logic [EW-1:0] en_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         en_run <= '0;
    else if (scan_en_o) en_run <= en_run + 1'b1;
    else                en_run <= '0;
  end

  // R2
  win_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en_o |-> (en_run < EW'(WIN)));

  // R2
  win_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scan_en_o) |-> (en_run == EW'(WIN)));

  // R2
  pat_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en_o && en_run == '0) |-> !scan_in_o);

  // R2
  pat_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en_o && en_run >= EW'(2)) |-> (scan_in_o != $past(scan_in_o, 2)));

  // R9
  busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en_o |-> !done_o);

  // R10
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && start_i) |=> (!done_o && scan_en_o));

  // R11
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> (done_o && $stable(fault_code_o) && $stable(fail_chain_o)));

  // R8
  good_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && fault_code_o == 3'd0) |-> (fail_chain_o == '0));

endmodule

bind chain_pattern_classifier cptc_checker #(
  .NUM_CHAINS (NUM_CHAINS),
  .CHAIN_LEN  (CHAIN_LEN)
) u_cptc_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .scan_in_o    (scan_in_o),
  .scan_en_o    (scan_en_o),
  .done_o       (done_o),
  .fault_code_o (fault_code_o),
  .fail_chain_o (fail_chain_o)
);

// File: tb/chain_pattern_classifier_bench.sv
module chain_pattern_classifier_bench;

  localparam int N   = 4;
  localparam int L   = 12;
  localparam int SW  = 2;
  localparam int WIN = 2 * L + 1;

  logic          clk = 1'b0;
  logic          rst_n, start, scan_out, scan_in, scan_en, done;
  logic [SW-1:0] sel, fidx;
  logic [2:0]    code;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  chain_pattern_classifier #(.NUM_CHAINS(N), .CHAIN_LEN(L)) u_chain_pattern_classifier (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start),
    .scan_out_i   (scan_out),
    .scan_in_o    (scan_in),
    .scan_en_o    (scan_en),
    .chain_sel_o  (sel),
    .done_o       (done),
    .fault_code_o (code),
    .fail_chain_o (fidx)
  );

  // chain models with fault injection on the unload
  logic [L-1:0] ch    [N];
  int           shcnt [N];
  logic [L-1:0] pre   [N];
  logic         smode [N];
  logic [3:0]   ssig  [N];
  logic         fen   [N];
  int           fpos  [N];
  logic         mclr;
  int           pat_err = 0;
  int           uk;
  logic         ub;

  always @(posedge clk) begin
    if (mclr) begin
      for (int i = 0; i < N; i++) begin
        ch[i]    <= pre[i];
        shcnt[i] <= 0;
      end
    end else if (scan_en) begin
      ch[sel]    <= {ch[sel][L-2:0], scan_in};
      shcnt[sel] <= shcnt[sel] + 1;
    end
  end

  always_comb begin
    uk = shcnt[sel] - L;
    ub = ch[sel][L-1];
    if (smode[sel] && uk >= 0) ub = ssig[sel][uk % 4];
    if (fen[sel] && uk == fpos[sel]) ub = ~ub;
    scan_out = ub;
  end

  always @(negedge clk) begin
    if (scan_en && (scan_in !== ((shcnt[sel] % 4) >= 2))) pat_err <= pat_err + 1;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // unload tables of R3..R6, bit p = value at period position p
  function automatic int exp_code(input int c);
    logic [3:0] s;
    if (fen[c]) return 7;
    s = smode[c] ? ssig[c] : 4'b1100;
    case (s)
      4'b1100: return 0;
      4'b0000: return 1;
      4'b1111: return 2;
      4'b0100: return 3;
      4'b1110: return 4;
      4'b1101: return 5;
      4'b1000: return 6;
      default: return 7;
    endcase
  endfunction

  task automatic clear_cfg();
    for (int i = 0; i < N; i++) begin
      smode[i] = 1'b0;
      ssig[i]  = 4'b0000;
      fen[i]   = 1'b0;
      fpos[i]  = 0;
    end
  endtask

  task automatic set_sig(input int c, input logic [3:0] s);
    smode[c] = 1'b1;
    ssig[c]  = s;
  endtask

  task automatic run_case(input string req, input bit poke);
    int ec, ei, k, n, pe0;
    ec = 0; ei = 0; k = N;
    for (int c = N - 1; c >= 0; c--) begin
      if (exp_code(c) != 0) begin
        ec = exp_code(c); ei = c; k = c + 1;
      end
    end
    // R7: garbage in the chains before each sweep
    for (int i = 0; i < N; i++) pre[i] = L'($urandom);
    mclr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    mclr = 1'b0;
    pe0 = pat_err;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk(!done, "R10", "done low after start", int'(done), 0);
    n = 1;
    while (!done && n < WIN * N + 20) begin
      start = poke && (n == 5);
      @(posedge clk);
      @(negedge clk);
      if (!done) n++;
    end
    start = 1'b0;
    chk(n == WIN * k, "R9", "sweep latency", n, WIN * k);
    chk(int'(code) == ec, req, "fault code", int'(code), ec);
    chk(int'(fidx) == ei, "R8", "failing chain index", int'(fidx), ei);
    chk(pat_err == pe0, "R2", "scan-in pattern errors", pat_err - pe0, 0);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [2:0] hc;
    logic [SW-1:0] hi;
    void'($urandom(32'd5171));
    rst_n = 1'b0;
    start = 1'b0;
    mclr  = 1'b0;
    clear_cfg();
    for (int i = 0; i < N; i++) pre[i] = '0;
    repeat (3) @(negedge clk);
    // R1
    chk(!scan_en && !done && !scan_in, "R1", "idle outputs", int'({scan_en, done, scan_in}), 0);
    chk(code == 3'd0 && fidx == '0, "R1", "reset results", int'({code, fidx}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!scan_en && !done, "R1", "idle after release", int'({scan_en, done}), 0);

    // R3 R7 all chains good, random preloads
    run_case("R3 R7", 1'b0);

    // R11 hold while done
    hc = code; hi = fidx;
    repeat (6) @(negedge clk);
    chk(done && code == hc && fidx == hi, "R11", "results held", int'({done, code}), int'({1'b1, hc}));

    // R4 stuck faults on chain 0
    clear_cfg(); set_sig(0, 4'b0000); run_case("R4", 1'b0);
    clear_cfg(); set_sig(0, 4'b1111); run_case("R4", 1'b0);

    // R5 timing faults
    clear_cfg(); set_sig(0, 4'b0100); run_case("R5", 1'b0);
    clear_cfg(); set_sig(1, 4'b1110); run_case("R5", 1'b0);
    clear_cfg(); set_sig(2, 4'b1101); run_case("R5", 1'b0);
    clear_cfg(); set_sig(3, 4'b1000); run_case("R5", 1'b0);

    // R6 unclassified patterns
    clear_cfg(); set_sig(1, 4'b1010); run_case("R6", 1'b0);
    clear_cfg(); fen[3] = 1'b1; fpos[3] = L - 1; run_case("R6", 1'b0);
    clear_cfg(); fen[2] = 1'b1; fpos[2] = 0; run_case("R6", 1'b0);

    // R8 lowest failing chain wins
    clear_cfg(); set_sig(3, 4'b0000); set_sig(1, 4'b1111); run_case("R8", 1'b0);

    // R10 start pulse inside a sweep is ignored
    clear_cfg(); set_sig(2, 4'b0100); run_case("R10", 1'b1);
    clear_cfg(); run_case("R10", 1'b1);

    // random mix
    for (int t = 0; t < 40; t++) begin
      clear_cfg();
      for (int c = 0; c < N; c++) begin
        int r;
        r = int'($urandom % 6);
        if (r == 3) set_sig(c, 4'($urandom));
        else if (r == 4) begin fen[c] = 1'b1; fpos[c] = int'($urandom % L); end
        else if (r == 5) begin
          case ($urandom % 6)
            0: set_sig(c, 4'b0000);
            1: set_sig(c, 4'b1111);
            2: set_sig(c, 4'b0100);
            3: set_sig(c, 4'b1110);
            4: set_sig(c, 4'b1101);
            default: set_sig(c, 4'b1000);
          endcase
        end
      end
      run_case("R3 R4 R5 R6", (t % 5) == 2);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule